// File: doc/BRIEF.md
# Configurable LUT Logic Cluster

This block is a small piece of programmable logic fabric. It holds a few logic elements. Each element has a lookup table with one stored bit for every combination of its inputs. The current input vector addresses the table directly, and the addressed bit is the element's function result. That result feeds a D flip-flop. A per-element configuration bit chooses whether the element presents the raw table result or the flip-flop value at the cluster output.

Each table input comes from its own source selector. A selector can pick any line of a shared bus of cluster inputs, or the flip-flop of any element in the cluster, so every element can see every element's stored state. A few select codes are not used, and these give a constant 0. Selector codes, table contents and output choices are all static configuration.

That configuration is loaded through a one-bit serial chain while a load-enable input is high. While loading, every flip-flop is held clear and the outputs read 0, so the user logic starts from a known state once loading ends.

Top module: `lut_cluster`

## Requirements
- R1: Each element output equals the stored table bit whose address is formed by its selector outputs, with selector j driving address bit j. The table bit for address a sits at element configuration bit a.
- R2: With table bits 0,1,1,0,1,0,0,1 at addresses 0 to 7 and address bit 3 tied to 0, an element behaves as a three-input exclusive OR of its first three selected lines.
- R3: Select codes 0 to 7 choose shared input line 0 to 7. Codes 8 to 11 choose the flip-flop of element 0 to 3. Codes 12 to 15 give a constant 0, regardless of the table bits at addresses that would need a 1 there.
- R4: Output-select bit (element configuration bit 16) at 0 presents the combinational table result; at 1 it presents the flip-flop, which loads the table result on every rising clock edge.
- R5: Feedback through codes 8 to 11 lets an element toggle from its own flip-flop, and lets other elements read that flip-flop in the same cycle.
- R6: Each clock edge with `cfg_en` high shifts one `cfg_din` bit into the chain, taking 132 edges in all. Stream bit b lands at chain bit b. Element e uses chain bits 33e to 33e+32, in this order: table bits for addresses 0 to 15, then the output-select bit, then four 4-bit selector codes, LSB first, for selectors 0 to 3. The configuration does not change while `cfg_en` is low.
- R7: The cluster has two named states, RUN and LOAD. The transition RUN to LOAD takes place on an edge with `cfg_en` high, and LOAD to RUN takes place on an edge with `cfg_en` low. While `cfg_en` is high, and for the rest of the LOAD state after it falls, all outputs are 0 and every flip-flop is cleared on each edge.
- R8: Reset clears all configuration and all flip-flops and enters RUN, so the outputs read 0 for any input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Configuration shift enable |
| cfg_din | input | 1 | Serial configuration data |
| clu_in | input | 8 | Shared cluster input lines |
| clu_out | output | 4 | Element outputs |

## Verification
The bench builds the cluster with its default sizes: four elements, four-input tables and eight shared lines. This gives twelve sources behind 4-bit select codes, so four spare codes (12 to 15) exist to test the constant-0 rule. Eight shared lines can be swept through all 256 patterns under a combinational image. A second image builds a feedback toggle and a delayed copy, and checks them against a cycle-stepped model over many cycles.

// File: rtl/lut_cluster_pkg.sv
package lut_cluster_pkg;
    localparam int N_ELEM   = 4;
    localparam int K_IN     = 4;
    localparam int N_SHARED = 8;

    localparam int SRC_N    = N_SHARED + N_ELEM;
    localparam int SEL_W    = $clog2(SRC_N);
    localparam int LUT_SIZE = 1 << K_IN;
    localparam int ELEM_W   = LUT_SIZE + 1 + K_IN * SEL_W;
    localparam int CHAIN_W  = ELEM_W * N_ELEM;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_LOAD = 1'b1
    } clu_state_t;
endpackage

// File: rtl/lut_cluster_cfg_chain.sv
module lut_cluster_cfg_chain #(
    parameter int W = 132
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] chain
);
    // First bit shifted in ends at index 0 after W shifts.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else if (shift_en) begin
            chain <= {din, chain[W-1:1]};
        end
    end
endmodule

// File: rtl/lut_cluster_elem.sv
module lut_cluster_elem #(
    parameter int K_IN  = 4,
    parameter int SRC_N = 12,
    parameter int SEL_W = 4,
    localparam int LUT_SIZE = 1 << K_IN,
    localparam int CFG_W    = LUT_SIZE + 1 + K_IN * SEL_W,
    localparam int PAD_N    = 1 << SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic [CFG_W-1:0] cfg,
    input  logic [SRC_N-1:0] src,
    output logic             q,
    output logic             y
);
    logic [LUT_SIZE-1:0] table_bits;
    logic                out_sel;
    logic [PAD_N-1:0]    src_pad;
    logic [K_IN-1:0]     addr;
    logic                lut_res;

    assign table_bits = cfg[LUT_SIZE-1:0];
    assign out_sel    = cfg[LUT_SIZE];

    // Unused codes index zero padding and read as constant 0.
    always_comb begin
        src_pad             = '0;
        src_pad[SRC_N-1:0]  = src;
    end

    for (genvar j = 0; j < K_IN; j++) begin : g_sel
        logic [SEL_W-1:0] code;
        assign code    = cfg[LUT_SIZE + 1 + j*SEL_W +: SEL_W];
        assign addr[j] = src_pad[code];
    end

    assign lut_res = table_bits[addr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (hold) begin
            q <= 1'b0;
        end else begin
            q <= lut_res;
        end
    end

    assign y = hold ? 1'b0 : (out_sel ? q : lut_res);
endmodule

// File: rtl/lut_cluster.sv
module lut_cluster
    import lut_cluster_pkg::*;
#(
    parameter int N_E = N_ELEM,
    parameter int K   = K_IN,
    parameter int N_S = N_SHARED,
    localparam int SRC   = N_S + N_E,
    localparam int SW    = $clog2(SRC),
    localparam int EW    = (1 << K) + 1 + K * SW,
    localparam int CW    = EW * N_E
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_en,
    input  logic           cfg_din,
    input  logic [N_S-1:0] clu_in,
    output logic [N_E-1:0] clu_out
);
    clu_state_t     state;
    logic           hold;
    logic [CW-1:0]  cfg_chain;
    logic [N_E-1:0] elem_q;
    logic [SRC-1:0] sources;

    // State register: RUN <-> LOAD follows the enable.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_RUN;
        end else begin
            state <= cfg_en ? ST_LOAD : ST_RUN;
        end
    end

    // Output decode of the state.
    always_comb begin
        unique case (state)
            ST_RUN:  hold = cfg_en;
            ST_LOAD: hold = 1'b1;
            default: hold = 1'b1;
        endcase
    end

    lut_cluster_cfg_chain #(.W(CW)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (cfg_en),
        .din      (cfg_din),
        .chain    (cfg_chain)
    );

    // Feedback is taken from the element flip-flops.
    assign sources = {elem_q, clu_in};

    for (genvar e = 0; e < N_E; e++) begin : g_elem
        lut_cluster_elem #(.K_IN(K), .SRC_N(SRC), .SEL_W(SW)) u_elem (
            .clk   (clk),
            .rst_n (rst_n),
            .hold  (hold),
            .cfg   (cfg_chain[e*EW +: EW]),
            .src   (sources),
            .q     (elem_q[e]),
            .y     (clu_out[e])
        );
    end
endmodule

// File: rtl/lut_cluster_chk.sv
module lut_cluster_chk
    import lut_cluster_pkg::*;
#(
    parameter int N = 4,
    parameter int W = 132
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cfg_en,
    input logic [N-1:0] clu_out,
    input logic [N-1:0] elem_q,
    input logic [W-1:0] cfg_chain,
    input clu_state_t   state
);
    AST_HOLD_OUT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |-> clu_out == '0); // R7

    AST_TAIL_OUT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cfg_en) |-> clu_out == '0); // R7

    AST_FF_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |=> elem_q == '0); // R7

    AST_ENTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |=> state == ST_LOAD); // R7

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> $stable(cfg_chain)); // R6
endmodule

bind lut_cluster lut_cluster_chk #(.N(N_E), .W(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_en    (cfg_en),
    .clu_out   (clu_out),
    .elem_q    (elem_q),
    .cfg_chain (cfg_chain),
    .state     (state)
);

// File: tb/lut_cluster_tb.sv
`timescale 1ns/1ps
module lut_cluster_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_en = 1'b0;
    logic       cfg_din = 1'b0;
    logic [7:0] clu_in = 8'h00;
    logic [3:0] clu_out;

    int n_checks = 0;
    int n_err    = 0;
    bit done     = 1'b0;

    typedef struct {
        logic [3:0] exp;
        string      tag;
    } item_t;
    item_t sb[$];
    item_t cur;

    always #2 clk = ~clk;

    lut_cluster u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_en  (cfg_en),
        .cfg_din (cfg_din),
        .clu_in  (clu_in),
        .clu_out (clu_out)
    );

    task automatic check(input logic [3:0] got, input logic [3:0] exp, input string tag);
        n_checks++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // Monitor: one scoreboard item per falling edge.
    always @(negedge clk) begin
        if (sb.size() != 0) begin
            cur = sb.pop_front();
            check(clu_out, cur.exp, cur.tag);
        end
    end

    // Driver: apply inputs, expect the result at the next falling edge.
    task automatic drive(input logic [7:0] din, input logic [3:0] exp, input string tag);
        item_t it;
        @(negedge clk);
        #1;
        clu_in = din;
        it.exp = exp;
        it.tag = tag;
        sb.push_back(it);
    endtask

    function automatic logic [32:0] elem(input logic [15:0] lut, input logic osel,
                                         input logic [3:0] s0, input logic [3:0] s1,
                                         input logic [3:0] s2, input logic [3:0] s3);
        return {s3, s2, s1, s0, osel, lut};
    endfunction

    task automatic load(input logic [131:0] img);
        clu_in = 8'hFF;
        for (int b = 0; b < 132; b++) begin
            @(negedge clk);
            #1;
            cfg_en  = 1'b1;
            cfg_din = img[b];
            if (b == 70) begin
                #0.5;
                check(clu_out, 4'h0, "R7 outputs held during load");
            end
        end
        @(negedge clk);
        #1;
        cfg_en = 1'b0;
        #0.5;
        check(clu_out, 4'h0, "R7 outputs held in LOAD after enable falls");
    endtask

    logic [131:0] img_a, img_b;

    initial begin
        logic       m_q0, m_q2, nq0;
        logic [7:0] v;
        logic [3:0] e;

        // Combinational image: XOR3, AND4, XOR4, registered AND2 via spare codes.
        img_a = {elem(16'hFFF8, 1'b1, 4'd1, 4'd2, 4'd12, 4'd13),
                 elem(16'h6996, 1'b0, 4'd0, 4'd3, 4'd5, 4'd7),
                 elem(16'h8000, 1'b0, 4'd4, 4'd5, 4'd6, 4'd7),
                 elem(16'hFF96, 1'b0, 4'd0, 4'd1, 4'd2, 4'd15)};
        // Feedback image: toggle, gated copy, delayed copy, constant 1.
        img_b = {elem(16'h0001, 1'b0, 4'd12, 4'd13, 4'd14, 4'd15),
                 elem(16'h0002, 1'b1, 4'd8, 4'd15, 4'd15, 4'd15),
                 elem(16'h0008, 1'b0, 4'd8, 4'd0, 4'd15, 4'd15),
                 elem(16'h5555, 1'b1, 4'd8, 4'd12, 4'd12, 4'd12)};

        clu_in = 8'hFF;
        repeat (3) @(negedge clk);
        #1 check(clu_out, 4'h0, "R8 reset outputs zero");
        rst_n = 1'b1;
        @(negedge clk);
        #1 check(clu_out, 4'h0, "R8 cleared config after reset");

        load(img_a);
        for (int i = 0; i < 256; i++) begin
            v = 8'(i);
            e[0] = v[0] ^ v[1] ^ v[2];             // R2
            e[1] = &v[7:4];                        // R1
            e[2] = v[0] ^ v[3] ^ v[5] ^ v[7];      // R1 R6
            e[3] = v[1] & v[2];                    // R3 R4
            drive(v, e, "R1 R2 R3 R4 R6 comb image");
        end

        load(img_b);
        m_q0 = 1'b0;
        m_q2 = 1'b0;
        for (int t = 0; t < 24; t++) begin
            v    = 8'(t * 37 + 5);
            nq0  = ~m_q0;
            m_q2 = m_q0;
            m_q0 = nq0;
            e = {1'b1, m_q2, m_q0 & v[0], m_q0};
            drive(v, e, "R4 R5 R3 feedback toggle");
        end

        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_err++;
            $display("FAIL watchdog got=timeout exp=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end
endmodule